// File: doc/BRIEF.md
# Masked Associative Memory with Validity States

This block is a content-addressable memory of wide words (64 bits by default) reached through a narrow 16-bit host bus. The host loads a search key, called the comparand, and the block compares it in parallel with every stored word that is eligible. The result is held in a status word with three fields: a hit flag, a multiple-hit flag and the lowest matching address. Every stored word carries a two-bit validity tag, and only words tagged valid take part in a search. The other three tag values keep a word out of every search. One of them marks a location as free, and a write to the next free location looks for that value.

Two mask registers can narrow what a search compares or what an array write changes. The control register picks which mask does which job. With a mask, a word can be split at any bit into a key field that is searched and an associated-data field that is not. Once a search hits, the host can read the matched word in full, including its associated data. A search runs by itself whenever the comparand, a mask or the control register is loaded, and it can also be started by command.

Top module: `assoc_mem`

## Requirements
- R1: After reset every location's tag is Empty, the status word reads 0 (hit, multiple-hit and full all clear, address 0), and the hit, multi_hit and full outputs are 0.
- R2: When bus_en is high, the pair {cmd_n,dat_n} selects the cycle: 00 command write, 01 data write, 10 status read, 11 data read. A 64-bit value moves as four data cycles, least significant halfword first. Each command write returns the halfword pointer to 0.
- R3: Tags are encoded as {skip,empty}: 00 Valid, 01 Empty, 10 Skip, 11 Random-access. Only Valid locations can match. Command opcode 4 (wdata[3:0]) writes tag wdata[5:4] to the location held in the address register. Opcode 2 loads the address register from wdata[15:4].
- R4: Control bits [1:0] select the compare mask: 00 none, 01 mask A, 10 mask B. A mask bit of 1 excludes that bit from the compare.
- R5: Control bits [3:2] select the write mask, with the same encoding as R4. A mask bit of 1 keeps the stored bit on any array write.
- R6: Opcode 1 selects the target of data writes from wdata[6:4]: 0 comparand, 1 mask A, 2 mask B, 3 control, 4 the array location in the address register, which is also set to Valid. Completing a load of targets 0 to 3, or issuing opcode 6, starts a compare. The status output changes one clock after the completing write. Nothing else changes the status.
- R7: On several matches the status reports the lowest matching address and sets the multiple-hit flag. On a miss the address field is 0.
- R8: Opcode 5 writes the comparand, under the write mask, to the lowest Empty location and sets that location to Valid. It does nothing while no Empty location remains. The full flag is high exactly while no location is Empty.
- R9: A status read returns {hit,multi,full} in bits 15:13 and the address in the low bits. Opcode 7 picks the data-read source from wdata[4]: 0 is the word at the status address (the matched word and its associated data), 1 is the word at the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | A bus cycle happens in this clock |
| cmd_n | input | 1 | Active-low command-select strobe |
| dat_n | input | 1 | Active-low data-select strobe |
| wdata | input | 16 | Command or data halfword from the host |
| rdata | output | 16 | Status or data halfword to the host, 0 outside read cycles |
| hit | output | 1 | Last compare found a match |
| multi_hit | output | 1 | Last compare found more than one match |
| full | output | 1 | No Empty location remains |

## Verification
Some properties are checked on every cycle. A command write always clears the halfword pointer. The status holds unless a compare is pending. The multiple-hit flag never appears without the hit flag. A push into a full array leaves it full. Any non-Valid tag write keeps that location out of the next match vector. The priority encoders always point at a set bit. Other behaviour only the bench's scenarios can show. This covers the exact lowest address under each mask choice, the write mask keeping stored bits, the one-clock latency, the difference between an automatic compare and an explicit one, the push filling a hole left in the array, and the matched word read back least significant halfword first.

// File: rtl/assoc_mem_pkg.sv
package assoc_mem_pkg;
   typedef enum logic [1:0] {
      TAG_VALID = 2'b00,
      TAG_EMPTY = 2'b01,
      TAG_SKIP  = 2'b10,
      TAG_RAND  = 2'b11
   } tag_e;

   localparam logic [3:0] OP_SELW = 4'd1;
   localparam logic [3:0] OP_ADDR = 4'd2;
   localparam logic [3:0] OP_TAG  = 4'd4;
   localparam logic [3:0] OP_PUSH = 4'd5;
   localparam logic [3:0] OP_CMP  = 4'd6;
   localparam logic [3:0] OP_RSRC = 4'd7;

   localparam logic [2:0] DST_KEY  = 3'd0;
   localparam logic [2:0] DST_MSKA = 3'd1;
   localparam logic [2:0] DST_MSKB = 3'd2;
   localparam logic [2:0] DST_CTRL = 3'd3;
   localparam logic [2:0] DST_ARR  = 3'd4;
endpackage

// File: rtl/assoc_lowest.sv
module assoc_lowest #(
   parameter int N  = 8,
   parameter int AW = 3
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic          multi,
   output logic [AW-1:0] idx
);
   initial assert (N >= 2 && (1 << AW) >= N) else $fatal(1, "assoc_lowest: bad N/AW");

   always_comb begin
      any   = |vec;
      multi = |(vec & (vec - N'(1)));
      idx   = '0;
      for (int i = N - 1; i >= 0; i--)
         if (vec[i]) idx = AW'(i);
   end

   // R7
   always_comb begin
      if (any) begin
         lowest_points_at_set_chk: assert (vec[idx]);
      end
   end
endmodule

// File: rtl/assoc_cam_array.sv
module assoc_cam_array
   import assoc_mem_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int WIDTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] wkeep,
   input  logic             tag_we,
   input  logic [AW-1:0]    tag_addr,
   input  tag_e             tag_val,
   input  logic [WIDTH-1:0] key,
   input  logic [WIDTH-1:0] cmask,
   input  logic [AW-1:0]    raddr_a,
   output logic [WIDTH-1:0] rdata_a,
   input  logic [AW-1:0]    raddr_b,
   output logic [WIDTH-1:0] rdata_b,
   output logic [DEPTH-1:0] match_vec,
   output logic [DEPTH-1:0] empty_vec
);
   initial assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $fatal(1, "assoc_cam_array: DEPTH must be a power of two");

   logic [WIDTH-1:0] words [DEPTH];
   tag_e             tags  [DEPTH];

   always_ff @(posedge clk)
      if (we) words[waddr] <= (words[waddr] & wkeep) | (wdata & ~wkeep);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tags[i] <= TAG_EMPTY;
      end else if (tag_we) begin
         tags[tag_addr] <= tag_val;
      end
   end

   assign rdata_a = words[raddr_a];
   assign rdata_b = words[raddr_b];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign match_vec[g] = (tags[g] == TAG_VALID) && (((words[g] ^ key) & ~cmask) == '0);
      assign empty_vec[g] = (tags[g] == TAG_EMPTY);

      // R3
      ineligible_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tag_we && tag_addr == AW'(g) && tag_val != TAG_VALID) |=> !match_vec[g]);
   end
endmodule

// File: rtl/assoc_mem.sv
module assoc_mem
   import assoc_mem_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int WIDTH = 64,
   parameter int BUS_W = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int NHALF = WIDTH / BUS_W,
   localparam int PW    = $clog2(NHALF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             cmd_n,
   input  logic             dat_n,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             hit,
   output logic             multi_hit,
   output logic             full
);
   initial assert (WIDTH % BUS_W == 0 && NHALF >= 2 && (1 << PW) == NHALF)
      else $fatal(1, "assoc_mem: WIDTH must be a power-of-two multiple of BUS_W");
   initial assert (BUS_W >= 8 && AW + 4 <= BUS_W)
      else $fatal(1, "assoc_mem: address does not fit the bus");

   logic is_cw, is_dw, is_cr, is_dr;
   assign is_cw = bus_en && !cmd_n && !dat_n;
   assign is_dw = bus_en && !cmd_n &&  dat_n;
   assign is_cr = bus_en &&  cmd_n && !dat_n;
   assign is_dr = bus_en &&  cmd_n &&  dat_n;

   logic [3:0] op;
   assign op = wdata[3:0];

   logic [WIDTH-1:0]       key_q, mska_q, mskb_q;
   logic [3:0]             ctrl_q;
   logic [WIDTH-BUS_W-1:0] asm_q;
   logic [PW-1:0]          ptr_q;
   logic [2:0]             dest_q;
   logic                   rsrc_q;
   logic [AW-1:0]          addr_q;
   logic                   cmp_go_q;
   logic                   st_hit_q, st_multi_q;
   logic [AW-1:0]          st_addr_q;

   logic                   last;
   logic [WIDTH-1:0]       full_word;
   assign last      = (ptr_q == PW'(NHALF - 1));
   assign full_word = {wdata, asm_q};

   function automatic logic [WIDTH-1:0] pick_mask(input logic [1:0] sel,
                                                  input logic [WIDTH-1:0] a,
                                                  input logic [WIDTH-1:0] b);
      case (sel)
         2'b01:   return a;
         2'b10:   return b;
         default: return '0;
      endcase
   endfunction

   logic [WIDTH-1:0] cmask, wkeep;
   assign cmask = pick_mask(ctrl_q[1:0], mska_q, mskb_q);
   assign wkeep = pick_mask(ctrl_q[3:2], mska_q, mskb_q);

   logic [DEPTH-1:0] match_vec, empty_vec;
   logic             m_any, m_multi, f_any, unused_free_multi;
   logic [AW-1:0]    m_idx, f_idx;

   assoc_lowest #(.N(DEPTH), .AW(AW)) u_match_pe (
      .vec(match_vec), .any(m_any), .multi(m_multi), .idx(m_idx));
   assoc_lowest #(.N(DEPTH), .AW(AW)) u_free_pe (
      .vec(empty_vec), .any(f_any), .multi(unused_free_multi), .idx(f_idx));

   assign full = !f_any;

   logic    push, arr_we, tag_we;
   logic [AW-1:0] arr_addr;
   tag_e    tag_val;
   assign push     = is_cw && op == OP_PUSH && !full;
   assign arr_we   = push || (is_dw && last && dest_q == DST_ARR);
   assign arr_addr = push ? f_idx : addr_q;
   assign tag_we   = arr_we || (is_cw && op == OP_TAG);
   assign tag_val  = (is_cw && op == OP_TAG) ? tag_e'(wdata[5:4]) : TAG_VALID;

   logic [WIDTH-1:0] word_at_match, word_at_addr, rd_word;

   assoc_cam_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
      .clk(clk), .rst_n(rst_n),
      .we(arr_we), .waddr(arr_addr), .wdata(push ? key_q : full_word), .wkeep(wkeep),
      .tag_we(tag_we), .tag_addr(arr_addr), .tag_val(tag_val),
      .key(key_q), .cmask(cmask),
      .raddr_a(st_addr_q), .rdata_a(word_at_match),
      .raddr_b(addr_q), .rdata_b(word_at_addr),
      .match_vec(match_vec), .empty_vec(empty_vec));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q <= '0; mska_q <= '0; mskb_q <= '0; ctrl_q <= '0; asm_q <= '0;
         ptr_q <= '0; dest_q <= DST_KEY; rsrc_q <= 1'b0; addr_q <= '0;
         cmp_go_q <= 1'b0; st_hit_q <= 1'b0; st_multi_q <= 1'b0; st_addr_q <= '0;
      end else begin
         if (is_cw) begin
            ptr_q <= '0;
            case (op)
               OP_SELW: dest_q <= wdata[6:4];
               OP_ADDR: addr_q <= wdata[4 +: AW];
               OP_RSRC: rsrc_q <= wdata[4];
               default: ;
            endcase
         end else if (is_dw || is_dr) begin
            ptr_q <= ptr_q + PW'(1);
         end
         if (is_dw) begin
            if (!last) asm_q[int'(ptr_q) * BUS_W +: BUS_W] <= wdata;
            else begin
               case (dest_q)
                  DST_KEY:  key_q  <= full_word;
                  DST_MSKA: mska_q <= full_word;
                  DST_MSKB: mskb_q <= full_word;
                  DST_CTRL: ctrl_q <= full_word[3:0];
                  default:  ;
               endcase
            end
         end
         cmp_go_q <= (is_dw && last && dest_q <= DST_CTRL) || (is_cw && op == OP_CMP);
         if (cmp_go_q) begin
            st_hit_q   <= m_any;
            st_multi_q <= m_multi;
            st_addr_q  <= m_any ? m_idx : '0;
         end
      end
   end

   logic [BUS_W-1:0] st_word;
   always_comb begin
      st_word            = '0;
      st_word[BUS_W-1]   = st_hit_q;
      st_word[BUS_W-2]   = st_multi_q;
      st_word[BUS_W-3]   = full;
      st_word[AW-1:0]    = st_addr_q;
   end

   assign rd_word = rsrc_q ? word_at_addr : word_at_match;
   assign rdata   = is_cr ? st_word : (is_dr ? rd_word[int'(ptr_q) * BUS_W +: BUS_W] : '0);

   assign hit       = st_hit_q;
   assign multi_hit = st_multi_q;

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^wdata;

   // R2
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cw |=> ptr_q == '0);
   // R6
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_go_q |=> $stable({st_hit_q, st_multi_q, st_addr_q}));
   // R7
   multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit |-> hit);
   // R8
   full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cw && op == OP_PUSH && full) |=> full);
endmodule

// File: tb/assoc_mem_test.sv
`timescale 1ns/1ps
module assoc_mem_test;
   logic        clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, cmd_n = 1'b1, dat_n = 1'b1;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        hit, multi_hit, full;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   assoc_mem #(.DEPTH(8)) uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cmd_n(cmd_n), .dat_n(dat_n),
      .wdata(wdata), .rdata(rdata), .hit(hit), .multi_hit(multi_hit), .full(full));

   localparam logic [63:0] E0 = 64'h1111_2222_3333_4444;
   localparam logic [63:0] E1 = 64'hAAAA_0000_0000_0001;
   localparam logic [63:0] E2 = 64'hAAAA_0000_0000_0002;
   localparam logic [63:0] MA = 64'h0000_0000_0000_FFFF;
   localparam logic [63:0] MB = 64'hFFFF_FFFF_FFFF_0000;

   localparam int NV = 8;
   localparam logic [3:0]  V_CTL [NV] = '{4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd2, 4'd2, 4'd1};
   localparam logic [63:0] V_KEY [NV] = '{E0, E1, E2, 64'h5555_5555_5555_5555,
      64'hAAAA_0000_0000_FFFF, 64'h0000_0000_0000_0002,
      64'h9999_9999_9999_4444, 64'h1111_2222_3333_0000};
   localparam logic [15:0] V_ST  [NV] = '{16'h8000, 16'hC001, 16'h8002, 16'h0000,
      16'hC001, 16'h8002, 16'h8000, 16'h8000};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic c, input logic d, input logic [15:0] v);
      @(negedge clk); bus_en = 1'b1; cmd_n = c; dat_n = d; wdata = v;
      @(negedge clk); bus_en = 1'b0; cmd_n = 1'b1; dat_n = 1'b1; wdata = '0;
   endtask

   task automatic rcyc(input logic d, output logic [15:0] v);
      @(negedge clk); bus_en = 1'b1; cmd_n = 1'b1; dat_n = d;
      #5 v = rdata;
      @(negedge clk); bus_en = 1'b0; dat_n = 1'b1;
   endtask

   task automatic cmdw(input logic [15:0] v); cyc(1'b0, 1'b0, v); endtask

   task automatic dwr64(input logic [63:0] v);
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, v[k*16 +: 16]);
   endtask

   task automatic load(input int dst, input logic [63:0] v);
      cmdw(16'(dst << 4) | 16'd1); dwr64(v);
   endtask

   task automatic set_addr(input int a); cmdw(16'(a << 4) | 16'd2); endtask
   task automatic set_tag(input int a, input int t); set_addr(a); cmdw(16'(t << 4) | 16'd4); endtask
   task automatic put(input int a, input logic [63:0] v); set_addr(a); load(4, v); endtask

   task automatic rd_status(output logic [15:0] s); rcyc(1'b0, s); endtask

   task automatic rd64(output logic [63:0] v);
      logic [15:0] h;
      for (int k = 0; k < 4; k++) begin rcyc(1'b1, h); v[k*16 +: 16] = h; end
   endtask

   task automatic settle; @(negedge clk); @(negedge clk); endtask

   initial begin
      #1ms;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] s, h0, h1;
      logic [63:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_status(s); chk("R1 status", 64'(s), 64'h0);
      chk("R1 outputs", {hit, multi_hit, full}, 3'b000);

      put(0, E0); put(1, E1); put(2, E2); put(3, E1);
      load(1, MA); load(2, MB);

      // R4 R7 R9 vector table walk
      for (int i = 0; i < NV; i++) begin
         load(3, 64'(V_CTL[i]));
         load(0, V_KEY[i]);
         settle();
         rd_status(s);
         chk($sformatf("R4/R7 vector %0d", i), 64'(s), 64'(V_ST[i]));
      end

      // R3 tag eligibility
      load(3, 64'd0);
      set_tag(2, 2); load(0, E2); settle(); rd_status(s); chk("R3 skip", 64'(s), 64'h0);
      set_tag(2, 3); cmdw(16'd6); settle(); rd_status(s); chk("R3 random-access", 64'(s), 64'h0);
      set_tag(2, 0); cmdw(16'd6); settle(); rd_status(s); chk("R3 valid again", 64'(s), 64'h8002);
      set_tag(3, 1); load(0, E1); settle(); rd_status(s); chk("R3 empty single hit", 64'(s), 64'h8001);
      set_tag(3, 0);

      // R6 latency and explicit compare
      load(0, 64'h5555_5555_5555_5555); settle();
      chk("R6 miss first", 64'(hit), 64'd0);
      load(0, E0);
      chk("R6 not yet", 64'(hit), 64'd0);
      @(negedge clk);
      chk("R6 one clock later", 64'(hit), 64'd1);
      set_tag(0, 2); settle();
      chk("R6 tag write no compare", 64'(hit), 64'd1);
      cmdw(16'd6); settle();
      chk("R6 explicit compare", 64'(hit), 64'd0);
      set_tag(0, 0);

      // R5 write mask keeps low halfword
      load(3, 64'd4);
      put(1, 64'hBBBB_CCCC_DDDD_EEEE);
      set_addr(1); cmdw(16'h0017); rd64(w);
      chk("R5 write mask", w, 64'hBBBB_CCCC_DDDD_0001);

      // R9 matched word read, R2 pointer reset
      load(3, 64'd2); load(0, 64'h2); settle();
      rd_status(s); chk("R9 status", 64'(s), 64'h8002);
      cmdw(16'h0007); rd64(w); chk("R9 matched word", w, E2);
      rcyc(1'b1, h0); rcyc(1'b1, h1);
      chk("R2 lsb first", {h1, h0}, 32'h0000_0002);
      cmdw(16'h0007); rd64(w); chk("R2 pointer reset", w, E2);

      // R8 next free and full
      load(3, 64'd0);
      load(0, 64'h7777_7777_7777_7777); cmdw(16'd5); cmdw(16'd6); settle();
      rd_status(s); chk("R8 push lowest empty", 64'(s), 64'h8004);
      for (int k = 5; k < 8; k++) begin
         load(0, 64'h7000_0000_0000_0000 | 64'(k)); cmdw(16'd5);
      end
      cmdw(16'd6); settle();
      rd_status(s); chk("R8 full status", 64'(s), 64'hA007);
      chk("R8 full port", 64'(full), 64'd1);
      load(0, 64'h8888_8888_8888_8888); cmdw(16'd5); cmdw(16'd6); settle();
      rd_status(s); chk("R8 push ignored when full", 64'(s), 64'h2000);
      set_tag(5, 1); settle();
      chk("R8 hole clears full", 64'(full), 64'd0);
      cmdw(16'd5); cmdw(16'd6); settle();
      rd_status(s); chk("R8 push fills hole", 64'(s), 64'hA005);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule